// File: doc/BRIEF.md
# Look-ahead pipelined exponential smoother

This block is a first-order recursive low-pass filter (an exponential moving average) that tracks a signed sample stream. It produces a slowly moving level that downstream logic uses as an adaptive threshold. A comparison flag tells, for every result, whether the sample that produced it lies above the smoothed level.

The plain recurrence y[n] = (1-c)·y[n-1] + c·x[n] places a multiply and an add inside a one-register feedback loop, which limits the clock rate. This block unrolls the recurrence by one step: s[n] = (1-c)²·s[n-2] + c(1-c)·x[n-1] + c·x[n]. The feedback path then passes through a product register and a state register, so the loop multiply and the loop add each get a full clock cycle. The three gains are computed from c when the coefficient is loaded, so they are off the loop.

A low enable freezes the whole pipeline, so gaps in the stream do not break the alignment between sample n and state n-2.

Top module: `iir_la_smoother`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it falls, `avg_y` is 0, `avg_vld` is 0 and `above` is 0. Reset also clears the sample history and the state history to zero, and sets the coefficient to 0.
- R2: A pulse on `coef_ld` with value c (unsigned Q0.16) sets the gains from the next cycle on. The gains are g0 = c, g1 = floor(c·(65536-c)/65536) and g2 = floor((65536-c)²/65536). Their sum always lies in [65535, 65536]. Loads are made while `smp_en` is low.
- R3: The internal state has 8 guard bits (Q1.23). Let x[n] be the n-th enabled sample (Q1.15). Then acc = g2·s[n-2] + 256·(g1·x[n-1] + g0·x[n]), and s[n] = floor((acc + 32768)/65536), saturated to 24-bit signed. s[-1], s[-2] and x[-1] are 0.
- R4: The output is y[n] = floor((s[n] + 128)/256), which is round-half-up, saturated to the range [-32768, 32767].
- R5: y[n] appears on `avg_y`, with `avg_vld` high for one cycle, after the clock edge that accepts sample n+1. Sample 0 alone gives no valid output, and the result for the last sample waits until a further sample is accepted.
- R6: In a cycle with `smp_en` low, the next cycle has `avg_vld` low, and `avg_y`, `above` and all histories are unchanged.
- R7: `above` is updated together with y[n] and is 1 exactly when x[n] > y[n] (strictly greater, signed).
- R8: With a coefficient whose gains are exact (0x4000, 0x8000), a constant input makes `avg_y` settle within 1 LSB of that input, including at both full-scale values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coef_ld | input | 1 | Loads `coef` and recomputes the three gains |
| coef | input | 16 | Smoothing coefficient c, unsigned Q0.16 |
| smp_en | input | 1 | Sample qualifier; low stalls the pipeline |
| smp_x | input | 16 | Input sample, signed Q1.15 |
| avg_y | output | 16 | Smoothed level, signed Q1.15 |
| avg_vld | output | 1 | One-cycle pulse marking a new `avg_y` |
| above | output | 1 | Sample behind the current result exceeds it |

## Verification
The new smoothed value and the threshold comparison are produced in the same cycle and from the same sample index. The comparison is made against the value being written, not the one already on the output. The bench drives a settled stream and then steps the input exactly one LSB above the level and then exactly at the level, which makes the strict-greater decision hinge on a freshly produced result. A scoreboard then judges the value and the flag together for every valid pulse. Random gaps of stalled cycles between samples confirm that the pair keeps its alignment with sample n-2 across interruptions.

// File: rtl/iir_la_pkg.sv
package iir_la_pkg;

   // rounding variant selected by the shift/saturate stage
   typedef enum logic [0:0] {
      RND_NEAREST = 1'b0,
      RND_TRUNC   = 1'b1
   } rnd_mode_e;

   // minimum fractional bits carried beyond the sample width
   localparam int GUARD_MIN = 8;

endpackage

// File: rtl/iir_la_gains.sv
module iir_la_gains #(
   parameter int CW = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld,
   input  logic [CW-1:0]       c,
   output logic [CW:0]         k0,
   output logic [CW:0]         k1,
   output logic [CW:0]         k2
);
   localparam int KW = CW + 1;
   localparam int MW = 2 * KW;
   localparam logic [KW-1:0] ONE = {1'b1, {CW{1'b0}}};

   logic [KW-1:0] c_ext, omc;
   logic [MW-1:0] m_mid, m_sq;
   logic [KW-1:0] k1_n, k2_n;

   always_comb begin
      c_ext = {1'b0, c};
      omc   = ONE - c_ext;
      m_mid = MW'(c_ext) * MW'(omc);
      m_sq  = MW'(omc) * MW'(omc);
      k1_n  = KW'(m_mid >> CW);
      k2_n  = KW'(m_sq >> CW);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         k0 <= '0;
         k1 <= '0;
         k2 <= ONE;
      end else if (ld) begin
         k0 <= c_ext;
         k1 <= k1_n;
         k2 <= k2_n;
      end
   end

   // R2: the three gains together stay at unity within the floor loss
   logic [KW+1:0] ksum;
   always_comb ksum = {2'b00, k0} + {2'b00, k1} + {2'b00, k2};

   a_r2_unity_gain: assert property (@(posedge clk) disable iff (rst)
      (ksum <= {1'b0, ONE}) && (ksum >= ({1'b0, ONE} - 1'b1)));

endmodule

// File: rtl/iir_la_round.sv
module iir_la_round #(
   parameter int                    IW   = 32,
   parameter int                    OW   = 16,
   parameter int                    SH   = 8,
   parameter iir_la_pkg::rnd_mode_e MODE = iir_la_pkg::RND_NEAREST
) (
   input  logic signed [IW-1:0] a,
   output logic signed [OW-1:0] y
);
   localparam int TW = IW + 1;
   localparam logic signed [TW-1:0] MAXV = {{(TW-OW+1){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [TW-1:0] MINV = {{(TW-OW+1){1'b1}}, {(OW-1){1'b0}}};

   if (SH < 1) begin : g_bad_sh
      $error("iir_la_round: shift must be at least one bit");
   end
   if (OW + SH > TW) begin : g_bad_ow
      $error("iir_la_round: output wider than shifted input");
   end

   logic signed [TW-1:0] ext, shifted;
   always_comb ext = {a[IW-1], a};

   if (MODE == iir_la_pkg::RND_NEAREST) begin : g_nearest
      localparam logic signed [TW-1:0] HALF = {{(TW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
      logic signed [TW-1:0] biased;
      always_comb begin
         biased  = ext + HALF;
         shifted = biased >>> SH;
      end
   end else begin : g_trunc
      always_comb shifted = ext >>> SH;
   end

   always_comb begin
      if (shifted > MAXV)      y = MAXV[OW-1:0];
      else if (shifted < MINV) y = MINV[OW-1:0];
      else                     y = shifted[OW-1:0];
   end

endmodule

// File: rtl/iir_la_loop.sv
module iir_la_loop #(
   parameter int                    DW   = 16,
   parameter int                    CW   = 16,
   parameter int                    GW   = 8,
   parameter iir_la_pkg::rnd_mode_e MODE = iir_la_pkg::RND_NEAREST
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [DW-1:0]     x0,
   input  logic signed [DW-1:0]     x1,
   input  logic [CW:0]              k0,
   input  logic [CW:0]              k1,
   input  logic [CW:0]              k2,
   output logic signed [DW+GW-1:0]  s_nxt,
   output logic signed [DW+GW-1:0]  s_q
);
   localparam int KW = CW + 1;
   localparam int SW = DW + GW;
   localparam int PW = SW + KW + 1;
   localparam int AW = PW + 2;

   // operands widened to the product width
   logic signed [PW-1:0] kk0, kk1, kk2, xx0, xx1, ss;
   always_comb begin
      kk0 = PW'($signed({1'b0, k0}));
      kk1 = PW'($signed({1'b0, k1}));
      kk2 = PW'($signed({1'b0, k2}));
      xx0 = PW'(x0);
      xx1 = PW'(x1);
      ss  = PW'(s_q);
   end

   // stage A: products, s_q holds s[n-2] here
   logic signed [PW-1:0] p0, p1, p2;
   always_ff @(posedge clk) begin
      if (rst) begin
         p0 <= '0;
         p1 <= '0;
         p2 <= '0;
      end else if (en) begin
         p0 <= (kk0 * xx0) <<< GW;
         p1 <= (kk1 * xx1) <<< GW;
         p2 <= kk2 * ss;
      end
   end

   // stage B: sum, round back to state precision, close the loop
   logic signed [AW-1:0] acc;
   always_comb acc = AW'(p0) + AW'(p1) + AW'(p2);

   iir_la_round #(
      .IW   (AW),
      .OW   (SW),
      .SH   (CW),
      .MODE (MODE)
   ) u_state_rnd (
      .a (acc),
      .y (s_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst)     s_q <= '0;
      else if (en) s_q <= s_nxt;
   end

   // R6: stalled cycles leave the loop state and products untouched
   a_r6_loop_frozen: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(s_q) && $stable(p2) && $stable(p0)));

endmodule

// File: rtl/iir_la_smoother.sv
module iir_la_smoother #(
   parameter int                    DW   = 16,
   parameter int                    CW   = 16,
   parameter int                    GW   = 8,
   parameter iir_la_pkg::rnd_mode_e MODE = iir_la_pkg::RND_NEAREST
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 coef_ld,
   input  logic [CW-1:0]        coef,
   input  logic                 smp_en,
   input  logic signed [DW-1:0] smp_x,
   output logic signed [DW-1:0] avg_y,
   output logic                 avg_vld,
   output logic                 above
);
   localparam int KW = CW + 1;
   localparam int SW = DW + GW;

   if (GW < iir_la_pkg::GUARD_MIN) begin : g_bad_gw
      $error("iir_la_smoother: too few guard bits");
   end
   if (DW < 4 || CW < 2) begin : g_bad_w
      $error("iir_la_smoother: sample or coefficient width too small");
   end

   logic [KW-1:0] k0, k1, k2;

   iir_la_gains #(.CW(CW)) u_gains (
      .clk (clk),
      .rst (rst),
      .ld  (coef_ld),
      .c   (coef),
      .k0  (k0),
      .k1  (k1),
      .k2  (k2)
   );

   // one-deep sample history, advanced only with the pipeline
   logic signed [DW-1:0] xh1;
   always_ff @(posedge clk) begin
      if (rst)         xh1 <= '0;
      else if (smp_en) xh1 <= smp_x;
   end

   logic signed [SW-1:0] s_nxt, s_q;

   iir_la_loop #(
      .DW   (DW),
      .CW   (CW),
      .GW   (GW),
      .MODE (MODE)
   ) u_loop (
      .clk   (clk),
      .rst   (rst),
      .en    (smp_en),
      .x0    (smp_x),
      .x1    (xh1),
      .k0    (k0),
      .k1    (k1),
      .k2    (k2),
      .s_nxt (s_nxt),
      .s_q   (s_q)
   );

   logic signed [DW-1:0] y_nxt;

   iir_la_round #(
      .IW   (SW),
      .OW   (DW),
      .SH   (GW),
      .MODE (MODE)
   ) u_out_rnd (
      .a (s_nxt),
      .y (y_nxt)
   );

   // primed after the first accepted sample; results lag one sample
   logic primed;
   always_ff @(posedge clk) begin
      if (rst) begin
         primed  <= 1'b0;
         avg_vld <= 1'b0;
         avg_y   <= '0;
         above   <= 1'b0;
      end else begin
         avg_vld <= smp_en & primed;
         if (smp_en) begin
            primed <= 1'b1;
            avg_y  <= y_nxt;
            above  <= (xh1 > y_nxt);
         end
      end
   end

   // R1: reset leaves a quiet output
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (avg_y == '0 && !avg_vld && !above));

   // R5: a valid result is always caused by an accepted sample
   a_r5_vld_needs_sample: assert property (@(posedge clk) disable iff (rst)
      avg_vld |-> $past(smp_en));

   // R6: no output activity after a stalled cycle
   a_r6_stall_quiet: assert property (@(posedge clk) disable iff (rst)
      !smp_en |=> (!avg_vld && $stable(avg_y) && $stable(above)));

   // R7: the flag cannot rise before any sample has entered
   a_r7_flag_needs_data: assert property (@(posedge clk) disable iff (rst)
      $rose(above) |-> $past(primed));

endmodule

// File: tb/iir_la_smoother_tb.sv
module iir_la_smoother_tb;
   localparam int CLK_NS = 10;
   localparam int DW = 16;
   localparam int CW = 16;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 coef_ld = 1'b0;
   logic [CW-1:0]        coef = '0;
   logic                 smp_en = 1'b0;
   logic signed [DW-1:0] smp_x = '0;
   logic signed [DW-1:0] avg_y;
   logic                 avg_vld;
   logic                 above;

   always #(CLK_NS/2) clk = ~clk;

   iir_la_smoother u_dut (
      .clk     (clk),
      .rst     (rst),
      .coef_ld (coef_ld),
      .coef    (coef),
      .smp_en  (smp_en),
      .smp_x   (smp_x),
      .avg_y   (avg_y),
      .avg_vld (avg_vld),
      .above   (above)
   );

   typedef struct {
      int y;
      bit hi;
   } exp_t;

   exp_t    q[$];
   int      checks = 0;
   int      errs = 0;
   bit      done = 1'b0;
   longint  g0, g1, g2, ms1, ms2, mx1;
   int      last_y = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint mround(input longint a, input int sh, input int ow);
      longint t, mx, mn;
      t  = (a + (64'sd1 <<< (sh - 1))) >>> sh;
      mx = (64'sd1 <<< (ow - 1)) - 1;
      mn = -(64'sd1 <<< (ow - 1));
      if (t > mx) return mx;
      if (t < mn) return mn;
      return t;
   endfunction

   task automatic set_gain(input longint c);
      g0 = c;
      g1 = (c * (65536 - c)) >>> 16;
      g2 = ((65536 - c) * (65536 - c)) >>> 16;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      smp_en = 1'b0;
      coef_ld = 1'b0;
      repeat (2) @(negedge clk);
      ms1 = 0; ms2 = 0; mx1 = 0;
      q.delete();
      last_y = 0;
      set_gain(0);
      rst = 1'b0;
      @(negedge clk);
      chk(avg_y == 0, "R1 reset level", avg_y, 0);
      chk(avg_vld == 1'b0, "R1 reset valid", avg_vld, 0);
      chk(above == 1'b0, "R1 reset flag", above, 0);
   endtask

   task automatic load(input int c);
      @(negedge clk);
      smp_en = 1'b0;
      coef_ld = 1'b1;
      coef = CW'(c);
      @(negedge clk);
      coef_ld = 1'b0;
      set_gain(c);
   endtask

   // driver: applies one sample and pushes its expected result
   task automatic send(input int x);
      longint acc, sn, yn;
      exp_t e;
      @(negedge clk);
      smp_en = 1'b1;
      smp_x = DW'(x);
      acc = g2 * ms2 + ((g1 * mx1 + g0 * longint'(x)) <<< 8);
      sn  = mround(acc, 16, 24);
      yn  = mround(sn, 8, 16);
      e.y  = int'(yn);
      e.hi = (longint'(x) > yn);
      q.push_back(e);
      ms2 = ms1;
      ms1 = sn;
      mx1 = x;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         smp_en = 1'b0;
      end
   endtask

   // monitor: pops and compares as results appear
   always @(negedge clk) begin
      if (!rst) begin
         if (avg_vld) begin
            if (q.size() == 0) begin
               chk(1'b0, "R5 valid without pending sample", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(avg_y == e.y, "R3/R4 smoothed value", avg_y, e.y);
               chk(above == e.hi, "R7 above flag", above, e.hi);
            end
            last_y = avg_y;
         end else begin
            chk(avg_y == last_y, "R6 level held while idle", avg_y, last_y);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 200000, 0);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      // R8: settle to a constant, then probe the strict comparison
      do_reset();
      load(16'h4000);
      send(1000);
      @(negedge clk);
      smp_en = 1'b0;
      chk(avg_vld == 1'b0, "R5 no output after first sample", avg_vld, 0);
      chk(q.size() == 1, "R5 first result pending", q.size(), 1);
      send(2000);
      @(negedge clk);
      smp_en = 1'b0;
      chk(avg_vld == 1'b1, "R5 first result after second sample", avg_vld, 1);
      for (int i = 0; i < 60; i++) send(12000);
      idle(2);
      chk(avg_y >= 11999 && avg_y <= 12001, "R8 settle positive", avg_y, 12000);
      send(12001);
      send(12001);
      send(12000);
      send(12000);
      idle(3);
      chk(q.size() == 1, "R5 last result waits", q.size(), 1);

      // R8: full-scale constants with an exact half coefficient
      do_reset();
      load(16'h8000);
      for (int i = 0; i < 40; i++) send(-32768);
      idle(2);
      chk(avg_y == -32768, "R8 negative full scale", avg_y, -32768);
      for (int i = 0; i < 40; i++) send(32767);
      idle(2);
      chk(avg_y >= 32766, "R8/R4 positive full scale", avg_y, 32767);

      // R2: zero coefficient keeps the level at its reset value
      do_reset();
      load(0);
      for (int i = 0; i < 20; i++) send((i % 2 == 0) ? 20000 : -15000);
      idle(2);
      chk(avg_y == 0, "R2 zero coefficient holds level", avg_y, 0);

      // R2: near-unity coefficient follows the input closely
      do_reset();
      load(16'hFFFF);
      for (int i = 0; i < 40; i++) send(int'($signed(16'($urandom))));
      idle(3);

      // R3/R6: random stream with random stall gaps
      do_reset();
      load(16'h1234);
      for (int i = 0; i < 400; i++) begin
         send(int'($signed(16'($urandom))));
         if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      end
      idle(3);
      chk(q.size() == 1, "R5 pending after random run", q.size(), 1);

      // R6: reset mid-stream discards the history
      do_reset();
      load(16'h2000);
      for (int i = 0; i < 30; i++) send(-9000 + i * 500);
      idle(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule